// File: doc/BRIEF.md
# Byte-Command I2C Master Controller

This block is an I2C master that a host drives one byte at a time through five small registers. It does not produce SCL and SDA waveforms. It issues abstract byte-level commands on a transaction port: open with an address byte, send a byte, receive a byte, or close the transfer. An external bus engine answers each command in the same cycle with a success or failure flag, and with the received byte when the command was a receive.

The host moves bytes by accessing the data register. In master mode, the first data write after a transfer opens is taken as the address byte. Later writes are sent as payload. A data read pulls the next byte from the target. The control register selects master mode, transmit or receive direction, interrupts and repeated start. If the enable bit is dropped while the block is enabled, a soft reset clears every register except the own-address register.

The interrupt line is the status interrupt flag. The flag is set after each acknowledged byte, but only when both enables are on. The host clears it by writing 0 to it.

Top module: `i2cByteMaster`

## Requirements
- R1: After reset, every register reads 0, irq is low and no command is issued. Register offsets: own address 0x00 (bits 7:1 kept), divider 0x04 (bits 5:0 kept), control 0x08, status 0x0C, data 0x10. Control bits: 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 ack-off, 2 repeated start; bits 1:0 read 0. Status bits: 5 busy, 1 interrupt flag, 0 received NACK; the others read 0.
- R2: A control write with bit 7 clear, while bit 7 is set, is a soft reset. Divider, control, status and stored read byte return to 0 and the open transfer is forgotten. If a transfer was open, a close command is issued. The own-address register keeps its value.
- R3: Any other control write stores the value masked to bits 7:2. Busy takes the value of the new master bit. If master is clear and a transfer is open, a close command is issued and the transfer is forgotten.
- R4: A control write with master and repeated start both set, while a transfer is open, issues a close command, forgets the transfer and clears the repeated-start bit. With no open transfer, the repeated-start bit is stored as written.
- R5: Commands appear on busCmd in the same cycle as the host access: 0 open, 1 send, 2 receive, 3 close. The byte is on busCmdByte and busOk is the response. In master mode with no open transfer, a data write issues an open command carrying the written byte (bits 7:1 target, bit 0 direction).
- R6: A refused open sets received NACK and leaves the transfer closed. An accepted open marks the transfer open, clears received NACK and raises the interrupt.
- R7: With a transfer open, a data write issues a send command. Acceptance clears received NACK and raises the interrupt. Refusal sets received NACK and forgets the transfer.
- R8: A data write has no effect and issues no command while enable is clear or master is clear.
- R9: In master mode, a data read returns the next byte and raises the interrupt when a transfer is open, transmit is clear and the receive succeeds. It returns 0xFF with no command when no transfer is open or transmit is set, and 0xFF when the receive fails. Outside master mode, a data read returns the last stored byte.
- R10: Raising the interrupt sets the status flag and irq only when enable and interrupt enable are both set.
- R11: Writing 0 to status bit 1 clears the flag and drops irq. Writing 1 has no effect.
- R12: Reads at unmapped offsets return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Register byte offset |
| hostWrEn | input | 1 | Write strobe, one cycle per access |
| hostRdEn | input | 1 | Read strobe, one cycle per access |
| hostWrData | input | 8 | Write value |
| hostRdData | output | 8 | Read value, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt, mirrors status flag |
| busCmdValid | output | 1 | Command issued this cycle |
| busCmd | output | 2 | Command code: 0 open, 1 send, 2 receive, 3 close |
| busCmdByte | output | 8 | Address or payload byte for open and send |
| busOk | input | 1 | Same-cycle response: acknowledged or succeeded |
| busRxByte | input | 8 | Received byte for a receive command |

## Verification
If the open-transfer flag goes wrong, the next data access shows it at once. An open command appears where a send was expected, or a receive is skipped and the read returns 0xFF. The close commands after control writes also go wrong. Status bit errors show on the next status read, and a wrong interrupt flag shows on irq one cycle after the access that should have moved it. Each access is checked in its own cycle: the command and byte on the transaction port, then the read value and irq one cycle later.

// File: rtl/i2cPkg.sv
`timescale 1ns/1ps
package i2cPkg;
  localparam int OFF_OWN  = 'h00;
  localparam int OFF_DIV  = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_DATA = 'h10;

  localparam logic [7:0] OWN_MASK  = 8'hFE;
  localparam logic [7:0] CTRL_MASK = 8'hFC;
  localparam int DIV_W = 6;

  localparam int B_EN = 7;
  localparam int B_IE = 6;
  localparam int B_MS = 5;
  localparam int B_TX = 4;
  localparam int B_RS = 2;
  localparam int S_BUSY = 5;
  localparam int S_IF = 1;

  typedef enum logic [1:0] {CMD_OPEN = 2'd0, CMD_SEND = 2'd1, CMD_RECV = 2'd2, CMD_CLOSE = 2'd3} busCmdE;
  typedef enum logic [2:0] {SEL_OWN, SEL_DIV, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_NONE} regSelE;

  typedef struct packed {
    logic   wrOwn;
    logic   wrDiv;
    logic   wrCtrl;
    logic   softRst;
    logic   wrStatus;
    logic   rdHit;
    regSelE rdSel;
    logic   setNack;
    logic   clrNack;
    logic   latchAddr;
    logic   dropAddr;
    logic   raiseInt;
    logic   loadRx;
    logic   clrRestart;
  } strobeT;
endpackage

// File: rtl/i2cCtrl.sv
`timescale 1ns/1ps
module i2cCtrl
  import i2cPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostWrData,
  input  logic              enabled,
  input  logic              master,
  input  logic              transmit,
  input  logic              addrValid,
  input  logic              busOk,
  output strobeT            st,
  output logic              busCmdValid,
  output busCmdE            busCmd,
  output logic [7:0]        busCmdByte
);
  regSelE sel;

  always_comb begin
    if (hostAddr == ADDR_W'(OFF_OWN))       sel = SEL_OWN;
    else if (hostAddr == ADDR_W'(OFF_DIV))  sel = SEL_DIV;
    else if (hostAddr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    else if (hostAddr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (hostAddr == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    st          = '0;
    st.rdSel    = SEL_NONE;
    busCmdValid = 1'b0;
    busCmd      = CMD_CLOSE;
    busCmdByte  = hostWrData;
    if (hostWrEn) begin
      unique case (sel)
        SEL_OWN:  st.wrOwn = 1'b1;
        SEL_DIV:  st.wrDiv = 1'b1;
        SEL_STAT: st.wrStatus = 1'b1;
        SEL_CTRL: begin
          if (enabled && !hostWrData[B_EN]) begin
            st.softRst  = 1'b1;
            busCmdValid = addrValid;
          end else begin
            st.wrCtrl = 1'b1;
            if (!hostWrData[B_MS]) begin
              busCmdValid = addrValid;
              st.dropAddr = 1'b1;
            end else if (hostWrData[B_RS] && addrValid) begin
              busCmdValid   = 1'b1;
              st.dropAddr   = 1'b1;
              st.clrRestart = 1'b1;
            end
          end
        end
        SEL_DATA: begin
          if (enabled && master) begin
            busCmdValid = 1'b1;
            busCmd      = addrValid ? CMD_SEND : CMD_OPEN;
            if (busOk) begin
              st.clrNack   = 1'b1;
              st.raiseInt  = 1'b1;
              st.latchAddr = !addrValid;
            end else begin
              st.setNack  = 1'b1;
              st.dropAddr = addrValid;
            end
          end
        end
        default: ;
      endcase
    end else if (hostRdEn) begin
      st.rdHit = 1'b1;
      st.rdSel = sel;
      if (sel == SEL_DATA && master) begin
        st.loadRx = 1'b1;
        if (addrValid && !transmit) begin
          busCmdValid = 1'b1;
          busCmd      = CMD_RECV;
          st.raiseInt = busOk;
        end
      end
    end
  end
endmodule

// File: rtl/i2cDatapath.sv
`timescale 1ns/1ps
module i2cDatapath
  import i2cPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     st,
  input  logic [7:0] hostWrData,
  input  logic       busCmdValid,
  input  busCmdE     busCmd,
  input  logic       busOk,
  input  logic [7:0] busRxByte,
  output logic [7:0] ctrlReg,
  output logic       addrValid,
  output logic [7:0] hostRdData,
  output logic       irq
);
  logic [7:0]       ownAddr;
  logic [DIV_W-1:0] divReg;
  logic             busy, intFlag, rxNack;
  logic [7:0]       dataRead, fetched, statusByte, rdNext;

  assign fetched    = (busCmdValid && busCmd == CMD_RECV && busOk) ? busRxByte : 8'hFF;
  assign statusByte = {2'b00, busy, 3'b000, intFlag, rxNack};
  assign irq        = intFlag;

  always_comb begin
    unique case (st.rdSel)
      SEL_OWN:  rdNext = ownAddr;
      SEL_DIV:  rdNext = 8'(divReg);
      SEL_CTRL: rdNext = ctrlReg;
      SEL_STAT: rdNext = statusByte;
      SEL_DATA: rdNext = st.loadRx ? fetched : dataRead;
      default:  rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0; divReg <= '0; ctrlReg <= '0;
      busy <= 1'b0; intFlag <= 1'b0; rxNack <= 1'b0;
      addrValid <= 1'b0; dataRead <= '0; hostRdData <= '0;
    end else begin
      if (st.rdHit) hostRdData <= rdNext;
      if (st.softRst) begin
        divReg <= '0; ctrlReg <= '0; busy <= 1'b0; intFlag <= 1'b0;
        rxNack <= 1'b0; addrValid <= 1'b0; dataRead <= '0;
      end else begin
        if (st.wrOwn) ownAddr <= hostWrData & OWN_MASK;
        if (st.wrDiv) divReg <= hostWrData[DIV_W-1:0];
        if (st.wrCtrl) begin
          ctrlReg <= (hostWrData & CTRL_MASK) & ~(8'(st.clrRestart) << B_RS);
          busy    <= hostWrData[B_MS];
        end
        if (st.wrStatus && !hostWrData[S_IF]) intFlag <= 1'b0;
        if (st.setNack) rxNack <= 1'b1;
        if (st.clrNack) rxNack <= 1'b0;
        if (st.latchAddr) addrValid <= 1'b1;
        if (st.dropAddr) addrValid <= 1'b0;
        if (st.raiseInt && ctrlReg[B_EN] && ctrlReg[B_IE]) intFlag <= 1'b1;
        if (st.loadRx) dataRead <= fetched;
      end
    end
  end

  assert_open_only_closed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && busCmd == CMD_OPEN) |-> !addrValid);
  assert_cmd_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid |-> ctrlReg[B_EN]);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(ctrlReg[B_EN] && ctrlReg[B_IE]));
  assert_own_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.softRst |=> $stable(ownAddr));
  assert_open_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && busCmd == CMD_OPEN && !busOk) |=> (rxNack && !addrValid));
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrStatus && !hostWrData[S_IF]) |=> !irq);
endmodule

// File: rtl/i2cByteMaster.sv
`timescale 1ns/1ps
module i2cByteMaster
  import i2cPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              irq,
  output logic              busCmdValid,
  output logic [1:0]        busCmd,
  output logic [7:0]        busCmdByte,
  input  logic              busOk,
  input  logic [7:0]        busRxByte
);
  strobeT     st;
  busCmdE     cmdCode;
  logic [7:0] ctrlReg;
  logic       addrValid;

  i2cCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostWrData(hostWrData),
    .enabled(ctrlReg[B_EN]), .master(ctrlReg[B_MS]), .transmit(ctrlReg[B_TX]),
    .addrValid(addrValid), .busOk(busOk), .st(st),
    .busCmdValid(busCmdValid), .busCmd(cmdCode), .busCmdByte(busCmdByte)
  );

  i2cDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .hostWrData(hostWrData),
    .busCmdValid(busCmdValid), .busCmd(cmdCode), .busOk(busOk), .busRxByte(busRxByte),
    .ctrlReg(ctrlReg), .addrValid(addrValid), .hostRdData(hostRdData), .irq(irq)
  );

  assign busCmd = cmdCode;
endmodule

// File: tb/test_i2cByteMaster.sv
`timescale 1ns/1ps
module test_i2cByteMaster;
  logic       clk = 1'b0, rstN = 1'b0;
  logic [4:0] hostAddr = '0;
  logic       hostWrEn = 1'b0, hostRdEn = 1'b0, busOk = 1'b0;
  logic [7:0] hostWrData = '0, busRxByte = '0;
  logic [7:0] hostRdData, busCmdByte;
  logic       irq, busCmdValid;
  logic [1:0] busCmd;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mOwn, mDiv, mCtrl, mData;
  bit mBusy, mIntF, mNack, mValid;

  always #10 clk = ~clk;

  i2cByteMaster i_i2cByteMaster (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq), .busCmdValid(busCmdValid),
    .busCmd(busCmd), .busCmdByte(busCmdByte), .busOk(busOk), .busRxByte(busRxByte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] statusVal();
    return {2'b00, mBusy, 3'b000, mIntF, mNack};
  endfunction

  function automatic void raiseModel();
    if (mCtrl[7] && mCtrl[6]) mIntF = 1'b1;
  endfunction

  task automatic access(input bit isWr, input logic [4:0] a, input logic [7:0] v,
                        input bit ok, input logic [7:0] rx, input string tag);
    bit eV = 0; logic [1:0] eC = 2'd3; logic [7:0] eRd = 8'h00;
    if (isWr) begin
      case (a)
        5'h00: mOwn = v & 8'hFE;
        5'h04: mDiv = v & 8'h3F;
        5'h08: begin
          if (mCtrl[7] && !v[7]) begin
            eV = mValid;
            mDiv = 0; mCtrl = 0; mBusy = 0; mIntF = 0; mNack = 0; mValid = 0; mData = 0;
          end else begin
            mCtrl = v & 8'hFC; mBusy = v[5];
            if (!v[5]) begin eV = mValid; mValid = 0; end
            else if (v[2] && mValid) begin eV = 1; mValid = 0; mCtrl[2] = 1'b0; end
          end
        end
        5'h0C: if (!v[1]) mIntF = 1'b0;
        5'h10: if (mCtrl[7] && mCtrl[5]) begin
          eV = 1;
          eC = mValid ? 2'd1 : 2'd0;
          if (ok) begin mValid = 1; mNack = 0; raiseModel(); end
          else begin mNack = 1; mValid = 0; end
        end
        default: ;
      endcase
    end else begin
      case (a)
        5'h00: eRd = mOwn;
        5'h04: eRd = mDiv;
        5'h08: eRd = mCtrl;
        5'h0C: eRd = statusVal();
        5'h10: begin
          if (mCtrl[5]) begin
            if (mValid && !mCtrl[4]) begin
              eV = 1; eC = 2'd2;
              mData = ok ? rx : 8'hFF;
              if (ok) raiseModel();
            end else mData = 8'hFF;
          end
          eRd = mData;
        end
        default: eRd = 8'h00;
      endcase
    end
    @(negedge clk);
    hostAddr = a; hostWrData = v; hostWrEn = isWr; hostRdEn = !isWr; busOk = ok; busRxByte = rx;
    #1;
    check({tag, " cmdValid"}, 32'(busCmdValid), 32'(eV));
    if (eV) check({tag, " cmd"}, 32'(busCmd), 32'(eC));
    if (eV && eC < 2) check({tag, " cmdByte"}, 32'(busCmdByte), 32'(v));
    @(negedge clk);
    hostWrEn = 0; hostRdEn = 0; busOk = 0;
    if (!isWr) check({tag, " rdData"}, 32'(hostRdData), 32'(eRd));
    check("R10 irq", 32'(irq), 32'(mIntF));
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v, input bit ok, input string tag);
    access(1'b1, a, v, ok, 8'h00, tag);
  endtask
  task automatic rd(input logic [4:0] a, input bit ok, input logic [7:0] rx, input string tag);
    access(1'b0, a, 8'h00, ok, rx, tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mOwn = 0; mDiv = 0; mCtrl = 0; mData = 0; mBusy = 0; mIntF = 0; mNack = 0; mValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 no command", 32'(busCmdValid), 0);
    for (int i = 0; i < 5; i++) rd(5'(i * 4), 1'b1, 8'h55, "R1 reset read");
    wr(5'h00, 8'hFF, 1'b1, "R1 own mask");   rd(5'h00, 1'b1, 8'h00, "R1 own mask");
    wr(5'h04, 8'hFF, 1'b1, "R1 div mask");   rd(5'h04, 1'b1, 8'h00, "R1 div mask");
    // R8 data write while disabled
    wr(5'h08, 8'h20, 1'b1, "R3 master no enable");
    wr(5'h10, 8'hA0, 1'b1, "R8 write disabled");
    rd(5'h0C, 1'b1, 8'h00, "R8 status unchanged");
    // R6 refused open, then accepted
    wr(5'h08, 8'hF0, 1'b1, "R3 enable master tx");
    wr(5'h10, 8'hA4, 1'b0, "R6 open refused");
    rd(5'h0C, 1'b1, 8'h00, "R6 nack set");
    wr(5'h10, 8'hA4, 1'b1, "R5 open accepted");
    rd(5'h0C, 1'b1, 8'h00, "R6 nack clear irq set");
    wr(5'h0C, 8'hFF, 1'b1, "R11 write one keeps");
    wr(5'h0C, 8'h00, 1'b1, "R11 write zero clears");
    wr(5'h10, 8'h3C, 1'b1, "R7 send ok");
    rd(5'h10, 1'b1, 8'h77, "R9 read with tx set");
    wr(5'h10, 8'h3D, 1'b0, "R7 send refused");
    wr(5'h10, 8'hA5, 1'b1, "R7 reopen after refusal");
    // R4 repeated start
    wr(5'h08, 8'hE4, 1'b1, "R4 restart open");
    rd(5'h08, 1'b1, 8'h00, "R4 restart cleared");
    wr(5'h08, 8'hE4, 1'b1, "R4 restart no transfer");
    rd(5'h08, 1'b1, 8'h00, "R4 restart kept");
    wr(5'h10, 8'hA5, 1'b1, "R9 open for read");
    rd(5'h10, 1'b1, 8'h5A, "R9 receive ok");
    rd(5'h10, 1'b0, 8'h5A, "R9 receive failed");
    // R12 unmapped
    wr(5'h14, 8'hFF, 1'b1, "R12 unmapped write");
    rd(5'h14, 1'b1, 8'h00, "R12 unmapped read");
    // R2 soft reset with transfer open
    wr(5'h00, 8'h6A, 1'b1, "R2 own set");
    wr(5'h04, 8'h15, 1'b1, "R2 div set");
    wr(5'h08, 8'h00, 1'b1, "R2 soft reset");
    for (int i = 0; i < 5; i++) rd(5'(i * 4), 1'b1, 8'h00, "R2 after soft reset");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 99);
      logic [4:0] a;
      logic [7:0] v = 8'($urandom);
      bit ok = ($urandom_range(0, 9) < 8);
      if (k < 8) a = 5'h00; else if (k < 12) a = 5'h04; else if (k < 30) a = 5'h08;
      else if (k < 42) a = 5'h0C; else if (k < 96) a = 5'h10; else a = 5'h14;
      if (a == 5'h08 && $urandom_range(0, 9) < 9) v[7] = 1'b1;
      if (a == 5'h08 && $urandom_range(0, 9) < 8) v[5] = 1'b1;
      if (a == 5'h08) v[2] = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 1) == 0)
        access(1'b1, a, v, ok, 8'h00, a == 5'h10 ? "R7 rnd write" : (a == 5'h08 ? "R3 rnd ctrl" : "R12 rnd write"));
      else
        access(1'b0, a, v, ok, 8'($urandom), a == 5'h10 ? "R9 rnd read" : "R1 rnd read");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule